// File: doc/BRIEF.md
# Hardwired Control Sequencer

This block is the control unit of a small accumulator CPU. It steps through four phases per instruction: fetch, decode, execute and operand fetch. The current phase is held as a 2-bit binary number. A decoder expands that number into one line per phase. Each line is gated with a condition input and routed into an OR encoder, which forms the next phase number. An encoder with no input asserted yields phase 0.

The datapath strobes are AND/OR combinations of the phase lines and the one-hot opcode lines that come from the instruction decoder. The memory-address-register load strobe fires on every fetch. It also fires during operand fetch, but only for opcodes that read an operand from memory. The shift-right select fires only while a shift-right opcode is in its execute phase. The opcode lines are held steady while an instruction runs. The phase lines are also brought out, so the datapath can use them for its own strobes.

Top module: `ctl_seq`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), the phase is fetch: step_o = 4'b0001, mar_ld_o = 1 and shift_sel_o = 0. These values appear without waiting for a clock edge.
- R2: step_o is always one-hot. Bit 0 is fetch, bit 1 is decode, bit 2 is execute and bit 3 is operand fetch.
- R3: Fetch moves to decode, and decode moves to execute, at the next rising edge whatever cond_i is.
- R4: From execute, the next rising edge moves to operand fetch if cond_i is 1, and to fetch if cond_i is 0.
- R5: Operand fetch always returns to fetch at the next rising edge.
- R6: mar_ld_o is 1 in fetch for every opcode, including when no opcode line is high.
- R7: In operand fetch, mar_ld_o is 1 only when the opcode is one of these: op_i bit 0 (load), bit 2 (add), bit 3 (subtract), bit 4 (and), bit 5 (or) or bit 6 (not). It is 0 for bit 1 (store), bit 7 (shift right) and bit 8 (halt). mar_ld_o is 0 in decode and in execute.
- R8: shift_sel_o is 1 exactly when the phase is execute and op_i bit 7 (shift right) is high.
- R9: The strobes are combinational from the registered phase and op_i. A change on op_i shows on the strobes without a clock edge.
- R10: The phase changes only at a rising clock edge. A change on cond_i between edges does not alter step_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the phase register loads on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to fetch |
| op_i | input | 9 | One-hot opcode lines from the instruction decoder |
| cond_i | input | 1 | Condition that selects operand fetch after execute |
| step_o | output | 4 | One-hot phase lines |
| mar_ld_o | output | 1 | Memory-address-register load strobe |
| shift_sel_o | output | 1 | Shift-right select strobe |

## Verification
The bench runs all nine opcodes through both branches out of execute. This catches an operand-fetch mask that is missing an opcode or includes an extra one: such a design would load the address register for a store or halt, or skip the load for one of the arithmetic opcodes. The bench also runs a cycle with no opcode line high. A fetch strobe that wrongly depends on the opcode would stay low there. It toggles cond_i and op_i between edges. A design that registers its strobes would lag by one cycle, and one that samples the condition combinationally into the phase would jump early. Finally, it pulls reset low in the middle of execute. A design with a synchronous reset would keep its execute strobes until the next edge.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  localparam int STATE_W = 2;
  localparam int NUM_ST  = 1 << STATE_W;
  localparam int NUM_OPS = 9;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_OPND   = 2'd3
  } phase_e;

  localparam int OP_LOD = 0;
  localparam int OP_STO = 1;
  localparam int OP_ADD = 2;
  localparam int OP_SUB = 3;
  localparam int OP_AND = 4;
  localparam int OP_OR  = 5;
  localparam int OP_NOT = 6;
  localparam int OP_SHR = 7;
  localparam int OP_HLT = 8;

  // opcodes that read an operand from memory
  localparam logic [NUM_OPS-1:0] OPND_MASK =
    (NUM_OPS'(1) << OP_LOD) | (NUM_OPS'(1) << OP_ADD) | (NUM_OPS'(1) << OP_SUB) |
    (NUM_OPS'(1) << OP_AND) | (NUM_OPS'(1) << OP_OR)  | (NUM_OPS'(1) << OP_NOT);
endpackage

// File: rtl/ctl_seq_state_dec.sv
module ctl_seq_state_dec #(
  parameter int STATE_W = 2,
  localparam int NUM_ST = 1 << STATE_W
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [NUM_ST-1:0]  line_o
);
  for (genvar i = 0; i < NUM_ST; i++) begin : g_line
    assign line_o[i] = (state_i == STATE_W'(i));
  end
endmodule

// File: rtl/ctl_seq_next_enc.sv
module ctl_seq_next_enc #(
  parameter int STATE_W = 2,
  localparam int NUM_ST = 1 << STATE_W
) (
  input  logic [NUM_ST-1:0]  req_i,
  output logic [STATE_W-1:0] next_o
);
  // no priority: requests OR together; input 0 carries no bits
  always_comb begin
    next_o = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      next_o = next_o | (req_i[i] ? STATE_W'(i) : '0);
    end
  end
endmodule

// File: rtl/ctl_seq_strobes.sv
module ctl_seq_strobes
  import ctl_seq_pkg::*;
(
  input  logic [NUM_ST-1:0]  line_i,
  input  logic [NUM_OPS-1:0] op_i,
  output logic               mar_ld_o,
  output logic               shift_sel_o
);
  logic opnd_op;

  assign opnd_op     = |(op_i & OPND_MASK);
  assign mar_ld_o    = line_i[ST_FETCH] | (line_i[ST_OPND] & opnd_op);
  assign shift_sel_o = line_i[ST_EXEC] & op_i[OP_SHR];
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OPS-1:0] op_i,
  input  logic               cond_i,
  output logic [NUM_ST-1:0]  step_o,
  output logic               mar_ld_o,
  output logic               shift_sel_o
);
  logic [STATE_W-1:0] state_q, state_d;
  logic [NUM_ST-1:0]  line, req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  ctl_seq_state_dec #(.STATE_W(STATE_W)) u_dec (
    .state_i (state_q),
    .line_o  (line)
  );

  // fetch target left unwired: empty request loads 0
  assign req[ST_FETCH]  = 1'b0;
  assign req[ST_DECODE] = line[ST_FETCH];
  assign req[ST_EXEC]   = line[ST_DECODE];
  assign req[ST_OPND]   = line[ST_EXEC] & cond_i;

  ctl_seq_next_enc #(.STATE_W(STATE_W)) u_enc (
    .req_i  (req),
    .next_o (state_d)
  );

  ctl_seq_strobes u_strb (
    .line_i      (line),
    .op_i        (op_i),
    .mar_ld_o    (mar_ld_o),
    .shift_sel_o (shift_sel_o)
  );

  assign step_o = line;

  // R2
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);
  // R3
  fetch_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o[ST_FETCH] |=> step_o[ST_DECODE]);
  // R3
  decode_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o[ST_DECODE] |=> step_o[ST_EXEC]);
  // R4
  exec_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[ST_EXEC] && cond_i) |=> step_o[ST_OPND]);
  // R4
  exec_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[ST_EXEC] && !cond_i) |=> step_o[ST_FETCH]);
  // R5
  opnd_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o[ST_OPND] |=> step_o[ST_FETCH]);
  // R6
  fetch_mar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o[ST_FETCH] |-> mar_ld_o);
  // R7
  mid_mar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[ST_DECODE] || step_o[ST_EXEC]) |-> !mar_ld_o);
  // R8
  shift_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_sel_o |-> (step_o[ST_EXEC] && op_i[OP_SHR]));
endmodule

// File: tb/ctl_seq_tb.sv
module ctl_seq_tb;
  import ctl_seq_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_OPS-1:0] op_i = '0;
  logic               cond_i = 1'b0;
  logic [NUM_ST-1:0]  step_o;
  logic               mar_ld_o;
  logic               shift_sel_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ctl_seq u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .cond_i      (cond_i),
    .step_o      (step_o),
    .mar_ld_o    (mar_ld_o),
    .shift_sel_o (shift_sel_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic [3:0] st, input logic mar, input logic sh);
    chk(step_o == st, {req, " step"}, int'(step_o), int'(st));
    chk(mar_ld_o == mar, {req, " mar_ld"}, int'(mar_ld_o), int'(mar));
    chk(shift_sel_o == sh, {req, " shift_sel"}, int'(shift_sel_o), int'(sh));
  endtask

  // one instruction from fetch back to fetch; entered 2 ns after a falling edge
  task automatic run_instr(input logic [NUM_OPS-1:0] op, input logic c);
    logic opnd = |(op & 9'b001111101);  // R7 load/add/sub/and/or/not
    op_i = op; cond_i = c;
    #1;
    chk_all("R6 fetch", 4'b0001, 1'b1, 1'b0);
    @(negedge clk_i); #2;
    chk_all("R3 decode", 4'b0010, 1'b0, 1'b0);
    @(negedge clk_i); #2;
    chk_all("R8 execute", 4'b0100, 1'b0, op[7]);
    @(negedge clk_i); #2;
    if (c) begin
      chk_all("R4 R7 operand", 4'b1000, opnd, 1'b0);
      @(negedge clk_i); #2;
      chk(step_o == 4'b0001, "R5 return", int'(step_o), 1);
    end else begin
      chk(step_o == 4'b0001, "R4 skip", int'(step_o), 1);
    end
  endtask

  task automatic t_reset();
    #1;
    chk_all("R1 reset", 4'b0001, 1'b1, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1; #2;
  endtask

  task automatic t_all_ops();
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < NUM_OPS; k++)
        run_instr(NUM_OPS'(1) << k, c[0]);
    run_instr('0, 1'b1);  // R6 fetch strobe with no opcode
  endtask

  task automatic t_comb_op();
    op_i = NUM_OPS'(1) << OP_SHR; cond_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i); #2;
    chk(shift_sel_o == 1'b1, "R9 shr in exec", int'(shift_sel_o), 1);
    op_i = NUM_OPS'(1) << OP_ADD; #1;
    chk(shift_sel_o == 1'b0, "R9 shift drop w/o edge", int'(shift_sel_o), 0);
    @(negedge clk_i); #2;
    chk(mar_ld_o == 1'b1, "R9 operand add", int'(mar_ld_o), 1);
    op_i = NUM_OPS'(1) << OP_STO; #1;
    chk(mar_ld_o == 1'b0, "R9 mar drop w/o edge", int'(mar_ld_o), 0);
    @(negedge clk_i); #2;
  endtask

  task automatic t_cond_glitch();
    op_i = NUM_OPS'(1) << OP_LOD; cond_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i); #1;
    cond_i = 1'b1; #1;
    chk(step_o == 4'b0100, "R10 cond between edges", int'(step_o), 4);
    cond_i = 1'b0; #1;
    chk(step_o == 4'b0100, "R10 cond between edges", int'(step_o), 4);
    @(negedge clk_i); #2;
    chk(step_o == 4'b0001, "R10 edge sample", int'(step_o), 1);
  endtask

  task automatic t_async_reset();
    op_i = NUM_OPS'(1) << OP_SHR; cond_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i); #2;
    chk(shift_sel_o == 1'b1, "R1 pre-reset exec", int'(shift_sel_o), 1);
    rst_ni = 1'b0; #1;
    chk_all("R1 async reset", 4'b0001, 1'b1, 1'b0);
    @(negedge clk_i); #1;
    chk_all("R1 held reset", 4'b0001, 1'b1, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk(step_o == 4'b0010, "R1 R3 after reset", int'(step_o), 2);
  endtask

  initial begin
    t_reset();
    t_all_ops();
    t_comb_op();
    t_cond_glitch();
    t_async_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule